// File: doc/BRIEF.md
# Mirror Card Reader/Punch Capture Engine

This block follows the traffic between a host processor and a real card reader/punch and keeps a copy of the card images. It never drives the bus. It only decodes the device commands and the per-column data transfers that the host performs anyway. It keeps two 80-word card buffers. One holds the card at the read station. The other holds the card waiting at the punch station. A PC-side agent loads and fetches these buffers through a small word-wide register port.

The PC-side agent learns of events through an ordered notification queue. Every accepted device command is copied into it. When a card cycle completes, the block adds a synthetic end-of-cycle entry. That entry tells the PC the station images are ready to collect, and it also says whether the punch station held a card before the cycle. Read transfers overwrite read-station words. Punch transfers OR bits into punch-station words. A read or a feed moves the read-station image to the punch station.

A mode input switches the block between mirror capture and virtual operation. Only the mirror behaviour is built here: in virtual mode the block ignores the bus and only the PC port remains active. If the queue is full, new entries are dropped.

Top module: `mcap_mirror`

## Requirements
- R1: When mirror mode is set and `cmd_valid_i` is high, the command is queued as a 4-bit entry `{1'b0, 1'b0, op}`. The operation codes are 0 read, 1 punch, 2 feed and 3 alternate stacker. A stacker command starts no cycle.
- R2: During a read cycle, the k-th data transfer (k counted from 0) overwrites word k of the read-station buffer with `data_word_i`.
- R3: During a punch cycle, the k-th data transfer ORs `data_word_i` into word k of the punch-station buffer.
- R4: A cycle takes exactly 80 transfers. The column count never exceeds 80. A transfer is ignored when no read or punch cycle is active, including after the 80th column.
- R5: One cycle after the 80th transfer, the block queues a synthetic entry `{1'b1, empty, op}`. Bit 3 marks it as synthetic and op is the cycle's code.
- R6: At the end of a read cycle the whole read-station image is copied into the punch-station buffer. A punch cycle changes neither buffer beyond its OR captures.
- R7: A feed command queues its command entry. In the next cycle, with no transfers needed, it queues the synthetic entry and advances the read-station image to the punch station.
- R8: The `empty` bit (bit 2) of a synthetic entry is 1 while the punch station is unoccupied. The station becomes occupied after the first read or feed advance. `hopper_load_i` makes it unoccupied.
- R9: `runout_i` clears both buffers, marks the punch station unoccupied and aborts any cycle in progress.
- R10: While `mode_virtual_i` is high, commands and transfers are ignored. No entry is queued and no buffer or cycle state changes.
- R11: A PC write stores `pc_wdata_i` at word `pc_addr_i` of the buffer chosen by `pc_sel_i` (0 read station, 1 punch station). A read returns the word on `pc_rdata_o` one clock after the address is presented.
- R12: Queue entries come out in the order they were posted. While `note_ready_i` is low, the head entry stays valid and unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_virtual_i | input | 1 | 1 = virtual operation (bus ignored), 0 = mirror capture |
| cmd_valid_i | input | 1 | Host issued a device control command |
| cmd_op_i | input | 2 | Command code: 0 read, 1 punch, 2 feed, 3 alternate stacker |
| data_valid_i | input | 1 | Host performed one column data transfer |
| data_word_i | input | 16 | Word stored to memory (read) or written to the device (punch) |
| hopper_load_i | input | 1 | Pulse: hopper reloaded, punch station empty |
| runout_i | input | 1 | Pulse: flush all cards out of the machine |
| pc_we_i | input | 1 | PC buffer write strobe |
| pc_sel_i | input | 1 | Buffer select: 0 read station, 1 punch station |
| pc_addr_i | input | 7 | Column address 0..79 |
| pc_wdata_i | input | 16 | PC write data |
| pc_rdata_o | output | 16 | PC read data, one clock latency |
| note_valid_o | output | 1 | Queue head valid |
| note_ready_i | input | 1 | PC takes the head entry |
| note_data_o | output | 4 | Queue head: {synthetic, empty, op} |

## Verification
The capture paths are driven with a ramp of distinct column values on a read cycle, so any off-by-one in the column index or a missing overwrite of PC-written data shows up. They are then driven with sparse bit patterns on a punch cycle laid over the earlier image, which separates an OR from an overwrite. A feed after a PC edit of the read station shows that the advance copies the whole image. A punch cycle leaves the punch buffer distinct from the read buffer, which shows that punching does not advance. A run-out in the middle of a cycle, followed by stray transfers, and a run of feeds around hopper reloads, show the cycle abort and the empty tag in both states. Virtual-mode traffic and a stalled queue show that ignored input leaves the buffers and the queue order unchanged.

// File: rtl/mcap_pkg.sv
package mcap_pkg;
  localparam int COLS_DEF  = 80;
  localparam int WORD_DEF  = 16;
  localparam int NOTE_W    = 4;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_PUNCH = 2'd1,
    OP_FEED  = 2'd2,
    OP_STACK = 2'd3
  } op_e;
endpackage

// File: rtl/mcap_seq.sv
module mcap_seq
  import mcap_pkg::*;
#(
  parameter int COLS = COLS_DEF,
  localparam int CW  = $clog2(COLS + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          flush_i,
  input  logic          cmd_valid_i,
  input  op_e           cmd_op_i,
  input  logic          data_valid_i,
  output logic [CW-1:0] col_o,
  output logic          active_o,
  output logic          cap_we_o,
  output op_e           op_o,
  output logic          eoc_o
);
  logic [CW-1:0] col_q;
  logic          active_q, eoc_q, start;
  op_e           op_q;

  assign start    = en_i && cmd_valid_i && (cmd_op_i != OP_STACK);
  assign cap_we_o = en_i && data_valid_i && active_q && !start && !flush_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q    <= '0;
      active_q <= 1'b0;
      eoc_q    <= 1'b0;
      op_q     <= OP_READ;
    end else if (flush_i) begin
      col_q    <= '0;
      active_q <= 1'b0;
      eoc_q    <= 1'b0;
    end else begin
      eoc_q <= 1'b0;
      if (start) begin
        op_q     <= cmd_op_i;
        col_q    <= '0;
        active_q <= (cmd_op_i != OP_FEED);
        eoc_q    <= (cmd_op_i == OP_FEED);   // feed ends at once
      end else if (cap_we_o) begin
        col_q <= col_q + 1'b1;
        if (col_q == CW'(COLS - 1)) begin
          active_q <= 1'b0;
          eoc_q    <= 1'b1;
        end
      end
    end
  end

  assign col_o    = col_q;
  assign active_o = active_q;
  assign op_o     = op_q;
  assign eoc_o    = eoc_q;
endmodule

// File: rtl/mcap_station.sv
module mcap_station #(
  parameter int COLS = 80,
  parameter int W    = 16,
  localparam int AW  = $clog2(COLS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              load_i,
  input  logic [COLS*W-1:0] load_img_i,
  input  logic              cap_we_i,
  input  logic              cap_or_i,
  input  logic [AW-1:0]     cap_addr_i,
  input  logic [W-1:0]      cap_data_i,
  input  logic              pc_we_i,
  input  logic [AW-1:0]     pc_addr_i,
  input  logic [W-1:0]      pc_data_i,
  output logic [COLS*W-1:0] img_o
);
  logic [W-1:0] mem [COLS];

  // priority: clear > bulk load > bus capture > PC write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int c = 0; c < COLS; c++) mem[c] <= '0;
    end else begin
      for (int c = 0; c < COLS; c++) begin
        if (clr_i)
          mem[c] <= '0;
        else if (load_i)
          mem[c] <= load_img_i[c*W +: W];
        else if (cap_we_i && cap_addr_i == AW'(c))
          mem[c] <= cap_or_i ? (mem[c] | cap_data_i) : cap_data_i;
        else if (pc_we_i && pc_addr_i == AW'(c))
          mem[c] <= pc_data_i;
      end
    end
  end

  for (genvar g = 0; g < COLS; g++) begin : g_img
    assign img_o[g*W +: W] = mem[g];
  end
endmodule

// File: rtl/mcap_note_fifo.sv
module mcap_note_fifo #(
  parameter int W     = 4,
  parameter int DEPTH = 4,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         a_valid_i,
  input  logic [W-1:0] a_data_i,
  input  logic         b_valid_i,
  input  logic [W-1:0] b_data_i,
  output logic         valid_o,
  input  logic         ready_i,
  output logic [W-1:0] data_o
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] head, tail, tail_b;
  logic [AW:0]   count, cnt_a;
  logic          acc_a, acc_b, pop;

  // entry a is ordered before entry b in the same cycle
  assign tail   = head + count[AW-1:0];
  assign acc_a  = a_valid_i && (count < (AW+1)'(DEPTH));
  assign cnt_a  = count + {{AW{1'b0}}, acc_a};
  assign acc_b  = b_valid_i && (cnt_a < (AW+1)'(DEPTH));
  assign tail_b = acc_a ? tail + 1'b1 : tail;
  assign pop    = valid_o && ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      head  <= '0;
      count <= '0;
    end else begin
      if (acc_a) mem[tail]   <= a_data_i;
      if (acc_b) mem[tail_b] <= b_data_i;
      if (pop)   head <= head + 1'b1;
      count <= cnt_a + {{AW{1'b0}}, acc_b} - {{AW{1'b0}}, pop};
    end
  end

  assign valid_o = (count != '0);
  assign data_o  = mem[head];
endmodule

// File: rtl/mcap_mirror.sv
module mcap_mirror
  import mcap_pkg::*;
#(
  parameter int COLS       = COLS_DEF,
  parameter int W          = WORD_DEF,
  parameter int NOTE_DEPTH = 4,
  localparam int AW        = $clog2(COLS),
  localparam int CW        = $clog2(COLS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_virtual_i,
  input  logic              cmd_valid_i,
  input  logic [1:0]        cmd_op_i,
  input  logic              data_valid_i,
  input  logic [W-1:0]      data_word_i,
  input  logic              hopper_load_i,
  input  logic              runout_i,
  input  logic              pc_we_i,
  input  logic              pc_sel_i,
  input  logic [AW-1:0]     pc_addr_i,
  input  logic [W-1:0]      pc_wdata_i,
  output logic [W-1:0]      pc_rdata_o,
  output logic              note_valid_o,
  input  logic              note_ready_i,
  output logic [NOTE_W-1:0] note_data_o
);
  logic              en, cap_we, active_q, eoc_q, occupied_q, advance;
  logic [CW-1:0]     col_q;
  op_e               cyc_op, cmd_op;
  logic [COLS*W-1:0] pr_img, pp_img;
  logic [W-1:0]      pc_rdata_q;

  assign en     = !mode_virtual_i;
  assign cmd_op = op_e'(cmd_op_i);

  mcap_seq #(.COLS(COLS)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en),
    .flush_i     (runout_i),
    .cmd_valid_i (cmd_valid_i),
    .cmd_op_i    (cmd_op),
    .data_valid_i(data_valid_i),
    .col_o       (col_q),
    .active_o    (active_q),
    .cap_we_o    (cap_we),
    .op_o        (cyc_op),
    .eoc_o       (eoc_q)
  );

  assign advance = eoc_q && (cyc_op != OP_PUNCH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       occupied_q <= 1'b0;
    else if (runout_i || hopper_load_i) occupied_q <= 1'b0;
    else if (advance)                  occupied_q <= 1'b1;
  end

  mcap_station #(.COLS(COLS), .W(W)) u_pre_read (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (runout_i),
    .load_i    (1'b0),
    .load_img_i('0),
    .cap_we_i  (cap_we && cyc_op == OP_READ),
    .cap_or_i  (1'b0),
    .cap_addr_i(col_q[AW-1:0]),
    .cap_data_i(data_word_i),
    .pc_we_i   (pc_we_i && !pc_sel_i),
    .pc_addr_i (pc_addr_i),
    .pc_data_i (pc_wdata_i),
    .img_o     (pr_img)
  );

  mcap_station #(.COLS(COLS), .W(W)) u_pre_punch (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (runout_i),
    .load_i    (advance),
    .load_img_i(pr_img),
    .cap_we_i  (cap_we && cyc_op == OP_PUNCH),
    .cap_or_i  (1'b1),
    .cap_addr_i(col_q[AW-1:0]),
    .cap_data_i(data_word_i),
    .pc_we_i   (pc_we_i && pc_sel_i),
    .pc_addr_i (pc_addr_i),
    .pc_data_i (pc_wdata_i),
    .img_o     (pp_img)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      pc_rdata_q <= '0;
    else if (int'(pc_addr_i) < COLS)
      pc_rdata_q <= pc_sel_i ? pp_img[int'(pc_addr_i)*W +: W]
                             : pr_img[int'(pc_addr_i)*W +: W];
    else
      pc_rdata_q <= '0;
  end
  assign pc_rdata_o = pc_rdata_q;

  mcap_note_fifo #(.W(NOTE_W), .DEPTH(NOTE_DEPTH)) u_notes (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .a_valid_i(eoc_q),
    .a_data_i ({1'b1, !occupied_q, cyc_op}),
    .b_valid_i(en && cmd_valid_i),
    .b_data_i ({2'b00, cmd_op_i}),
    .valid_o  (note_valid_o),
    .ready_i  (note_ready_i),
    .data_o   (note_data_o)
  );
endmodule

// File: rtl/mcap_mirror_chk.sv
module mcap_mirror_chk #(
  parameter int COLS = 80,
  parameter int W    = 16,
  parameter int CW   = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mode_virtual_i,
  input logic              hopper_load_i,
  input logic              runout_i,
  input logic              note_valid_o,
  input logic              note_ready_i,
  input logic [3:0]        note_data_o,
  input logic [CW-1:0]     col_q,
  input logic              active_q,
  input logic              eoc_q,
  input logic              occupied_q,
  input logic              advance,
  input logic [COLS*W-1:0] pr_img,
  input logic [COLS*W-1:0] pp_img
);
  // R4
  col_le_cols_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(col_q) <= COLS);

  // R5
  eoc_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoc_q |-> !active_q);

  // R10
  virt_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_virtual_i |=> !eoc_q);

  // R6
  advance_copy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    advance && !runout_i |=> pp_img == $past(pr_img));

  // R8
  hopper_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hopper_load_i |=> !occupied_q);

  // R9
  runout_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    runout_i |=> !active_q && col_q == '0 && !occupied_q && pr_img == '0 && pp_img == '0);

  // R12
  note_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    note_valid_o && !note_ready_i |=> note_valid_o && $stable(note_data_o));
endmodule

bind mcap_mirror mcap_mirror_chk #(.COLS(COLS), .W(W), .CW(CW)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .mode_virtual_i(mode_virtual_i),
  .hopper_load_i (hopper_load_i),
  .runout_i      (runout_i),
  .note_valid_o  (note_valid_o),
  .note_ready_i  (note_ready_i),
  .note_data_o   (note_data_o),
  .col_q         (col_q),
  .active_q      (active_q),
  .eoc_q         (eoc_q),
  .occupied_q    (occupied_q),
  .advance       (advance),
  .pr_img        (pr_img),
  .pp_img        (pp_img)
);

// File: tb/mcap_mirror_bench.sv
module mcap_mirror_bench;
  localparam logic [1:0] RD = 2'd0, PU = 2'd1, FD = 2'd2, ST = 2'd3;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        mode_virt = 1'b0, cmd_valid = 1'b0, data_valid = 1'b0;
  logic [1:0]  cmd_op = 2'd0;
  logic [15:0] data_word = '0, pc_wdata = '0;
  logic        hopper = 1'b0, runout = 1'b0, pc_we = 1'b0, pc_sel = 1'b0;
  logic [6:0]  pc_addr = '0;
  logic [15:0] pc_rdata;
  logic        note_valid, note_ready = 1'b1;
  logic [3:0]  note_data;

  always #2 clk = ~clk;

  mcap_mirror u_mcap_mirror (
    .clk_i(clk), .rst_ni(rst_n), .mode_virtual_i(mode_virt),
    .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op), .data_valid_i(data_valid),
    .data_word_i(data_word), .hopper_load_i(hopper), .runout_i(runout),
    .pc_we_i(pc_we), .pc_sel_i(pc_sel), .pc_addr_i(pc_addr),
    .pc_wdata_i(pc_wdata), .pc_rdata_o(pc_rdata), .note_valid_o(note_valid),
    .note_ready_i(note_ready), .note_data_o(note_data)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  bit occ = 1'b0;
  logic [3:0] exp_q[$];
  string      tag_q[$];

  task automatic chk(string r, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h exp %h", r, what, act, exp);
    end
  endtask

  task automatic push(logic [3:0] n, string t);
    exp_q.push_back(n);
    tag_q.push_back(t);
  endtask

  // monitor: pops expected entries as the design hands them out
  always @(negedge clk) begin
    if (rst_n && note_valid && note_ready) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R12 unexpected note: got %h exp none", note_data);
      end else begin
        logic [3:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, "note", 32'(note_data), 32'(e));
      end
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic synth(logic [1:0] op, string t);
    push({1'b1, ~occ, op}, t);
    if (op != PU) occ = 1'b1;
  endtask

  task automatic cmd(logic [1:0] op, string t);
    cmd_valid = 1'b1; cmd_op = op;
    if (!mode_virt) push({2'b00, op}, t);
    @(negedge clk);
    cmd_valid = 1'b0;
    if (!mode_virt && op == FD) synth(op, "R7");
  endtask

  task automatic xfer(logic [15:0] w);
    data_valid = 1'b1; data_word = w;
    @(negedge clk);
    data_valid = 1'b0;
  endtask

  task automatic pc_wr(logic s, logic [6:0] a, logic [15:0] d);
    pc_we = 1'b1; pc_sel = s; pc_addr = a; pc_wdata = d;
    @(negedge clk);
    pc_we = 1'b0;
  endtask

  task automatic pc_rd(logic s, logic [6:0] a, output logic [15:0] d);
    pc_sel = s; pc_addr = a;
    @(negedge clk);
    d = pc_rdata;
  endtask

  task automatic pulse(ref logic sig);
    sig = 1'b1;
    @(negedge clk);
    sig = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout exp completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(1);

    // reset state
    chk("R12", "valid after reset", 32'(note_valid), 0);
    pc_rd(1'b0, 7'd0, d); chk("R11", "pre-read[0] reset", 32'(d), 0);

    // PC port
    pc_wr(1'b0, 7'd5, 16'h1234);
    pc_rd(1'b0, 7'd5, d); chk("R11", "pre-read[5] readback", 32'(d), 32'h1234);
    pc_rd(1'b1, 7'd5, d); chk("R11", "pre-punch[5] untouched", 32'(d), 0);

    // read cycle with a ramp
    pulse(hopper);
    cmd(RD, "R1");
    for (int c = 0; c < 80; c++) xfer(16'(c * 3 + 1));
    synth(RD, "R5");
    idle(3);
    pc_rd(1'b0, 7'd0, d);  chk("R2", "pre-read[0]", 32'(d), 1);
    pc_rd(1'b0, 7'd5, d);  chk("R2", "pre-read[5] overwritten", 32'(d), 16);
    pc_rd(1'b0, 7'd79, d); chk("R2", "pre-read[79]", 32'(d), 238);
    pc_rd(1'b1, 7'd79, d); chk("R6", "pre-punch[79] advanced", 32'(d), 238);
    pc_rd(1'b1, 7'd5, d);  chk("R6", "pre-punch[5] advanced", 32'(d), 16);

    // stray transfer after column 80
    xfer(16'hFFFF);
    idle(2);
    pc_rd(1'b0, 7'd0, d); chk("R4", "pre-read[0] after stray", 32'(d), 1);

    // punch cycle: OR over previous image
    cmd(PU, "R1");
    xfer(16'h8000);
    xfer(16'h0002);
    for (int c = 2; c < 80; c++) xfer(16'h0000);
    synth(PU, "R5");
    xfer(16'h00F0);
    idle(3);
    pc_rd(1'b1, 7'd0, d); chk("R3", "pre-punch[0] ORed", 32'(d), 32'h8001);
    pc_rd(1'b1, 7'd1, d); chk("R3", "pre-punch[1] ORed", 32'(d), 6);
    pc_rd(1'b1, 7'd2, d); chk("R3", "pre-punch[2] kept", 32'(d), 7);
    pc_rd(1'b0, 7'd0, d); chk("R6", "pre-read[0] after punch", 32'(d), 1);

    // feed after PC edit
    pc_wr(1'b0, 7'd10, 16'hABCD);
    cmd(FD, "R1");
    idle(3);
    pc_rd(1'b1, 7'd10, d); chk("R7", "pre-punch[10] fed", 32'(d), 32'hABCD);
    pc_rd(1'b1, 7'd0, d);  chk("R7", "pre-punch[0] fed", 32'(d), 1);

    // stacker command: note only
    cmd(ST, "R1");
    idle(3);

    // virtual mode ignores bus
    mode_virt = 1'b1;
    cmd(RD, "R10");
    for (int c = 0; c < 3; c++) xfer(16'h5555);
    idle(3);
    pc_rd(1'b0, 7'd0, d); chk("R10", "pre-read[0] in virtual", 32'(d), 1);
    mode_virt = 1'b0;
    idle(1);

    // run-out in mid cycle
    cmd(RD, "R1");
    for (int c = 0; c < 5; c++) xfer(16'h0F0F);
    pulse(runout);
    occ = 1'b0;
    for (int c = 0; c < 3; c++) xfer(16'h3333);
    idle(3);
    pc_rd(1'b0, 7'd2, d);  chk("R9", "pre-read[2] cleared", 32'(d), 0);
    pc_rd(1'b0, 7'd0, d);  chk("R9", "pre-read[0] cleared", 32'(d), 0);
    pc_rd(1'b1, 7'd10, d); chk("R9", "pre-punch[10] cleared", 32'(d), 0);

    // empty tag around hopper reloads
    cmd(FD, "R9");
    idle(2);
    cmd(FD, "R8");
    idle(2);
    pulse(hopper);
    occ = 1'b0;
    cmd(FD, "R8");
    idle(4);

    // queue stall
    note_ready = 1'b0;
    cmd(FD, "R12");
    idle(3);
    chk("R12", "stall valid", 32'(note_valid), 1);
    chk("R12", "stall head", 32'(note_data), 32'h2);
    idle(1);
    chk("R12", "stall head held", 32'(note_data), 32'h2);
    note_ready = 1'b1;
    idle(10);
    chk("R12", "queue drained", 32'(exp_q.size()), 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule